// File: doc/BRIEF.md
# Shared-Memory Bank Allocator

This block picks a memory bank for each cell entering a shared-memory switch whose cell store is split across K single-ported banks. Each bank does one access per timeslot, either a read or a write. In every timeslot up to N cells arrive. Each arrival carries the number of timeslots until it will leave. Up to N cells that were placed earlier are read out in the same timeslot. The allocator answers in the same cycle with a bank for every arrival. The chosen bank is not written by another arrival in this slot and is not read in this slot. It is also not already taken by another cell that leaves in the same future slot.

One clock cycle is one timeslot. A free-running slot counter indexes a circular reservation table with H entries. Each entry is a K-bit mask of the banks that hold cells due to leave in that slot. The current slot's entry is driven out as the read mask. That entry is emptied at the end of the slot, and the new arrivals' banks are added to the entries of their departure slots. The arrivals are served one after another in port order. Each takes the lowest-numbered bank still allowed. When K is at least 3N-1 and no future slot is given more than N cells, a bank is always free. An error flag reports an arrival that could not be placed.

Top module: `bank_alloc`

## Requirements
- R1: After reset the read mask is zero for the next H slots, no arrival is granted while none is offered, and the error flag is low.
- R2: Arrival ports are served in order from port 0 upward. Each granted port receives the lowest-numbered bank that is not read this slot, not given to a lower port this slot, and not reserved for its departure slot. Its bank number is output in bits [i*BW +: BW] of arr_bank.
- R3: No two ports granted in the same slot receive the same bank.
- R4: A granted bank is never a bank whose bit is set in the current read mask.
- R5: A granted bank is never a bank already reserved for the same departure slot by a cell from an earlier slot.
- R6: A cell granted with offset d (bits [i*OW +: OW] of arr_off, 1 to H-1) sets bit <bank> of the read mask exactly d cycles after its arrival cycle.
- R7: A table entry is emptied after its slot is read. A slot with no new reservations reads as zero when it comes round again H cycles later.
- R8: An offered arrival with offset 0 is not granted, asserts err in that cycle, and reserves nothing.
- R9: An offered arrival for which no bank is eligible is not granted, asserts err in that cycle, and reserves nothing. err is high exactly when some offered arrival is not granted.
- R10: A port whose arr_valid bit is low is not granted and takes no bank from the higher ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one timeslot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | N | Arrival offered on each port |
| arr_off | input | N*OW | Per-port departure offset in slots, 1 to H-1 |
| arr_bank | output | N*BW | Per-port granted bank number |
| arr_ok | output | N | Per-port grant |
| rd_mask | output | K | Banks read in the current slot |
| err | output | 1 | Some offered arrival could not be placed |

## Verification
Placement and read-out happen in the same slot. The arrivals of a slot must avoid the banks that the table is reading for that slot, while cells reserved earlier come due at that moment. Random traffic is kept within N cells per future slot, so most slots read several banks while up to three arrivals are placed. A reference table in the bench predicts every grant and every read mask. A directed case fills one future slot over three slots until all eight banks are reserved for it. A further arrival aimed at that slot must then raise the error flag and leave the table unchanged.

// File: rtl/bank_alloc.sv
module bank_alloc #(
  parameter int N = 3,
  parameter int K = 8,
  parameter int H = 16,
  localparam int BW = $clog2(K),
  localparam int OW = $clog2(H)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    arr_valid,
  input  logic [N*OW-1:0] arr_off,
  output logic [N*BW-1:0] arr_bank,
  output logic [N-1:0]    arr_ok,
  output logic [K-1:0]    rd_mask,
  output logic            err
);
  logic [K-1:0]  resv   [H];
  logic [K-1:0]  resv_n [H];
  logic [OW-1:0] cur;
  logic [OW-1:0] dep    [N];
  logic [K-1:0]  gnt    [N];
  logic [K-1:0]  tk;
  logic [K-1:0]  cand;

  assign rd_mask = resv[cur];
  assign err     = |(arr_valid & ~arr_ok);

  always_comb begin
    tk       = rd_mask;
    arr_bank = '0;
    arr_ok   = '0;
    cand     = '0;
    for (int i = 0; i < N; i++) begin
      dep[i] = cur + arr_off[i*OW +: OW];
      gnt[i] = '0;
      cand   = ~(tk | resv[dep[i]]);
      if (arr_valid[i] && arr_off[i*OW +: OW] != '0 && cand != '0) begin
        arr_ok[i] = 1'b1;
        for (int b = K-1; b >= 0; b--)
          if (cand[b]) arr_bank[i*BW +: BW] = BW'(b);
        gnt[i] = K'(1) << arr_bank[i*BW +: BW];
      end
      tk = tk | gnt[i];
    end
  end

  always_comb begin
    for (int h = 0; h < H; h++) begin
      resv_n[h] = (OW'(h) == cur) ? '0 : resv[h];
      for (int i = 0; i < N; i++)
        if (arr_ok[i] && dep[i] == OW'(h)) resv_n[h] = resv_n[h] | gnt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0;
      for (int h = 0; h < H; h++) resv[h] <= '0;
    end else begin
      cur <= cur + 1'b1;
      for (int h = 0; h < H; h++) resv[h] <= resv_n[h];
    end
  end
endmodule

// File: rtl/bank_alloc_chk.sv
module bank_alloc_chk #(
  parameter int N = 3,
  parameter int K = 8,
  parameter int H = 16,
  localparam int BW = $clog2(K),
  localparam int OW = $clog2(H)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    arr_valid,
  input logic [N*OW-1:0] arr_off,
  input logic [N*BW-1:0] arr_bank,
  input logic [N-1:0]    arr_ok,
  input logic [K-1:0]    rd_mask,
  input logic            err
);
  for (genvar i = 0; i < N; i++) begin : g_port
    a_r4_avoid_read: assert property (@(posedge clk) disable iff (!rst_n)
      arr_ok[i] |-> !rd_mask[arr_bank[i*BW +: BW]]);
    a_r8_zero_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_valid[i] && arr_off[i*OW +: OW] == '0) |-> (!arr_ok[i] && err));
    a_r10_idle_port: assert property (@(posedge clk) disable iff (!rst_n)
      !arr_valid[i] |-> !arr_ok[i]);
    for (genvar j = i + 1; j < N; j++) begin : g_pair
      a_r3_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_ok[i] && arr_ok[j]) |-> (arr_bank[i*BW +: BW] != arr_bank[j*BW +: BW]));
    end
  end
endmodule

bind bank_alloc bank_alloc_chk #(.N(N), .K(K), .H(H)) chk_i (.*);

// File: tb/bank_alloc_tb_top.sv
`timescale 1ns/1ps
module bank_alloc_tb_top;
  localparam int N = 3;
  localparam int K = 8;
  localparam int H = 16;
  localparam int BW = $clog2(K);
  localparam int OW = $clog2(H);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    arr_valid = '0;
  logic [N*OW-1:0] arr_off = '0;
  logic [N*BW-1:0] arr_bank;
  logic [N-1:0]    arr_ok;
  logic [K-1:0]    rd_mask;
  logic            err;

  int checks = 0;
  int errors = 0;
  logic [K-1:0]  mres [H];
  logic [OW-1:0] mcur;

  always #2 clk = ~clk;

  bank_alloc #(.N(N), .K(K), .H(H)) dut_i (.*);

  task automatic check(input bit c, input string tag, input int act, input int exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] v, input logic [N*OW-1:0] o, input string rtag);
    logic [K-1:0] used, rdm, cand;
    logic [OW-1:0] d, oi;
    logic [BW-1:0] eb, ab;
    bit eok, experr;
    @(negedge clk);
    arr_valid = v;
    arr_off = o;
    #1;
    rdm = mres[mcur];
    used = rdm;
    experr = 0;
    check(rd_mask == rdm, rtag, int'(rd_mask), int'(rdm));
    for (int i = 0; i < N; i++) begin
      oi = o[i*OW +: OW];
      d = mcur + oi;
      eok = 0;
      eb = '0;
      cand = ~(used | mres[d]);
      if (v[i] && oi != '0 && cand != '0) begin
        eok = 1;
        for (int b = K-1; b >= 0; b--) if (cand[b]) eb = BW'(b);
      end
      if (v[i] && !eok) experr = 1;
      check(arr_ok[i] == eok, !v[i] ? "R10" : (oi == '0 ? "R8" : "R2"), int'(arr_ok[i]), int'(eok));
      ab = arr_bank[i*BW +: BW];
      if (eok && arr_ok[i]) begin
        check(ab == eb, "R2", int'(ab), int'(eb));
        check(!rdm[ab], "R4", int'(rdm), 0);
        check(!mres[d][ab], "R5", int'(mres[d]), 0);
        check(!(used & ~rdm & (K'(1) << ab)), "R3", int'(ab), int'(eb));
        used = used | (K'(1) << eb);
        mres[d] = mres[d] | (K'(1) << eb);
      end
    end
    check(err == experr, "R9", int'(err), int'(experr));
    mres[mcur] = '0;
    mcur = mcur + 1'b1;
  endtask

  task automatic idle(input int n, input string rtag);
    for (int c = 0; c < n; c++) step('0, '0, rtag);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    logic [N*OW-1:0] o;
    logic [OW-1:0] off, d;
    int pc [H];
    void'($urandom(32'd1357));
    for (int h = 0; h < H; h++) mres[h] = '0;
    mcur = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet state after reset
    idle(H, "R1");

    // random traffic, at most N cells per future slot
    for (int c = 0; c < 3000; c++) begin
      for (int h = 0; h < H; h++) pc[h] = 0;
      v = '0;
      o = '0;
      for (int i = 0; i < N; i++) begin
        if ($urandom % 10 < 7) begin
          off = OW'(1 + $urandom % (H - 1));
          d = mcur + off;
          if ($countones(mres[d]) + pc[d] < N) begin
            v[i] = 1'b1;
            o[i*OW +: OW] = off;
            pc[d]++;
          end
        end
        if ($urandom % 60 == 0) begin
          v[i] = 1'b1;
          o[i*OW +: OW] = '0;
        end
      end
      step(v, o, "R6");
    end

    // R7: everything drains after H idle slots
    idle(H, "R7");

    // R9: one future slot filled to all K banks, then one more arrival
    step(3'b111, {OW'(5), OW'(5), OW'(5)}, "R7");
    step(3'b111, {OW'(4), OW'(4), OW'(4)}, "R7");
    step(3'b011, {OW'(0), OW'(3), OW'(3)}, "R7");
    step(3'b001, {OW'(0), OW'(0), OW'(2)}, "R7");
    check(arr_ok == '0, "R9", int'(arr_ok), 0);
    check(err == 1'b1, "R9", int'(err), 1);
    step('0, '0, "R7");
    step('0, '0, "R6");
    check(rd_mask == {K{1'b1}}, "R6", int'(rd_mask), (1 << K) - 1);
    idle(H - 1, "R7");
    step('0, '0, "R7");
    check(rd_mask == '0, "R7", int'(rd_mask), 0);

    // R10: idle lower port leaves bank 0 to a higher port
    step(3'b100, {OW'(1), OW'(0), OW'(0)}, "R6");
    check(arr_ok == 3'b100 && arr_bank[2*BW +: BW] == '0, "R10", int'(arr_bank), 0);
    // R4: next slot reads bank 0, new arrival must move to bank 1
    step(3'b001, {OW'(0), OW'(0), OW'(2)}, "R6");
    check(arr_bank[BW-1:0] == BW'(1), "R4", int'(arr_bank[BW-1:0]), 1);
    idle(H, "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule